// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet FIFO

This block is the packet store for one USB pipe. It sits between a CPU-side data port and the serial interface engine (SIE). It holds one or two planes of `PLANE_BYTES` bytes each. At any time each plane belongs either to the CPU or to the SIE. On a transmit pipe the CPU fills its plane and then issues a buffer-valid command. That command passes the plane to the SIE, and the SIE returns the plane empty when it reports that the packet has been sent. On a receive pipe the SIE fills a plane and ends the packet, which passes the plane to the CPU. The CPU drains the plane through the data port.

The CPU watches a single port-ready flag. It has two commands: a clear that throws away the contents of its own plane, and the buffer-valid command. A clear issued together with buffer-valid sends a zero-length packet. A received zero-length packet, or a short packet fully read while buffer-free hold is on, leaves the ready flag at 1 with no data left to read. The CPU then needs a clear to move on. When the pipe is marked as the default control pipe, the block always works with one plane, and a clear also takes back a plane that the SIE holds.

The configuration inputs are held stable while reset is released. Changing them requires a reset. The read-data outputs show the byte at the current position (look-ahead). A read strobe or pop strobe moves to the next byte.

Top module: `ep_pkt_fifo`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `port_rdy`, `cpu_cnt`, `cpu_rdata`, `sie_tx_req`, `sie_tx_len`, `sie_tx_data` and `sie_rx_ready` are 0.
- R2: On a transmit pipe, each `cpu_wr` with `port_rdy`=1 stores one byte in the CPU plane and raises `cpu_cnt` by one. Writes beyond `PLANE_BYTES` are dropped. A write in the same cycle as a clear or buffer-valid command is dropped.
- R3: Buffer-valid (`cmd_bval`=1 while `port_rdy`=1, transmit) passes the CPU plane to the SIE. `sie_tx_req` rises, `sie_tx_len` shows its byte count, and `sie_tx_data` presents the bytes in write order, one per `sie_tx_pop`. `sie_tx_done` returns the plane empty to the CPU. With two planes the CPU moves on to the other plane, and `port_rdy` stays 1 if that plane is free. The SIE sends planes in the order they were handed over.
- R4: With one plane, `port_rdy` is 0 from the cycle after buffer-valid until the cycle after the SIE returns the plane (transmit), or until a packet ends (receive).
- R5: A clear (`cmd_clr`=1) empties only the plane the CPU owns. A plane already handed to the SIE keeps its length. On a pipe that is not the control pipe, a clear while `port_rdy`=0 has no effect.
- R6: `cmd_clr` and `cmd_bval` asserted in the same cycle on a transmit pipe discard the written bytes and hand the SIE a packet with `sie_tx_len`=0.
- R7: With `cfg_ctrl`=1 only one plane is used, whatever `cfg_dual` says. A clear empties the plane even while the SIE holds it: on transmit the plane returns to the CPU and `sie_tx_req` falls; on receive the partly received bytes are discarded.
- R8: On a receive pipe, `sie_rx_ready` is 1 while the SIE owns a plane. Each `sie_rx_wr` stores a byte (up to `PLANE_BYTES`). `sie_rx_end` passes the plane to the CPU, and `port_rdy`=1 with `cpu_cnt` equal to the length. `cpu_rdata` shows the bytes in arrival order, one per `cpu_rd`. With buffer-free hold off, reading the last byte returns the plane to the SIE.
- R9: With two receive planes both held by the CPU, one clear frees only the current plane. `port_rdy` stays 1 and `cpu_cnt` shows the other packet.
- R10: A zero-length received packet gives `port_rdy`=1 and `cpu_cnt`=0, and `cpu_rdata`=0. Reads do not release the plane; only a clear does.
- R11: With `cfg_bfree`=1, fully reading a packet shorter than `PLANE_BYTES` leaves `port_rdy`=1 with `cpu_rdata`=0 until a clear. A full-size packet is released after its last byte as usual.
- R12: `cpu_wr` and `cpu_rd` while `port_rdy`=0 change no stored state, and `cpu_rdata` reads 0 then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx | input | 1 | 1: transmit pipe, 0: receive pipe |
| cfg_dual | input | 1 | Use two planes |
| cfg_ctrl | input | 1 | Pipe is the default control pipe |
| cfg_bfree | input | 1 | Hold a drained short packet until cleared |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DATA_W | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe (advance) |
| cpu_rdata | output | DATA_W | Byte at the CPU read position |
| cmd_clr | input | 1 | Clear command |
| cmd_bval | input | 1 | Buffer-valid command |
| port_rdy | output | 1 | CPU may access the data port |
| cpu_cnt | output | CNT_W | Byte count of the CPU plane |
| sie_tx_req | output | 1 | A plane is queued for sending |
| sie_tx_len | output | CNT_W | Length of the queued packet |
| sie_tx_pop | input | 1 | SIE takes one byte |
| sie_tx_data | output | DATA_W | Byte at the SIE send position |
| sie_tx_done | input | 1 | Packet sent, plane released |
| sie_rx_ready | output | 1 | SIE owns a plane to receive into |
| sie_rx_wr | input | 1 | SIE write strobe |
| sie_rx_wdata | input | DATA_W | SIE write byte |
| sie_rx_end | input | 1 | Received packet complete |

## Verification
The bench builds the block with `PLANE_BYTES`=8 and `DATA_W`=8. With that size, a full plane, an overflowing write burst and a full-size packet under buffer-free hold each take only a few cycles. Across resets it runs one and two planes in both directions, the control-pipe setting and the buffer-free hold. This makes the crossings between the two sides reachable: a clear against a plane queued to the SIE, two received packets waiting at once, and the two transmit planes being handed back in order.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;

  // Which side owns a plane: a plane is "loaned" when it sits away from its
  // home side (CPU for transmit, SIE for receive).
  function automatic logic cpu_holds(input logic is_tx, input logic loaned);
    return is_tx ? ~loaned : loaned;
  endfunction

  typedef logic plane_t;

endpackage

// File: rtl/ep_plane_mem.sv
module ep_plane_mem #(
  parameter int PLANE_BYTES = 64,
  parameter int DATA_W      = 8,
  localparam int AW         = $clog2(PLANE_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wplane,
  input  logic [AW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rplane,
  input  logic [AW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata
);

  // Storage array: no reset, contents are only read below a valid count.
  logic [DATA_W-1:0] mem_q [2][PLANE_BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[wplane][widx] <= wdata;
    end
  end

  assign rdata = mem_q[rplane][ridx];

endmodule

// File: rtl/ep_own_ctrl.sv
module ep_own_ctrl
  import ep_fifo_pkg::*;
#(
  parameter int PLANE_BYTES = 64,
  localparam int CW         = $clog2(PLANE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tx,
  input  logic          dual_eff,
  input  logic          cfg_ctrl,
  input  logic          cfg_bfree,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cmd_clr,
  input  logic          cmd_bval,
  input  logic          sie_tx_pop,
  input  logic          sie_tx_done,
  input  logic          sie_rx_wr,
  input  logic          sie_rx_end,
  output logic          port_rdy,
  output logic          sie_ok,
  output plane_t        cpu_plane,
  output plane_t        sie_plane,
  output logic [CW-1:0] cpu_cnt_raw,
  output logic [CW-1:0] sie_cnt_raw,
  output logic [CW-1:0] rptr,
  output logic [CW-1:0] sptr,
  output logic          wr_en
);

  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [CW-1:0] CNT_FULL = CW'(PLANE_BYTES);

  logic          alive_q, alive_n;
  logic [1:0]    loaned_q, loaned_n;
  logic [CW-1:0] cnt_q [2];
  logic [CW-1:0] cnt_n [2];
  plane_t        cur_q, cur_n, sp_q, sp_n;
  logic [CW-1:0] rptr_q, rptr_n, sptr_q, sptr_n;

  // Gated events, all judged on registered state
  logic cpu_wr_ok, cpu_rd_ok, clr_ok, bval_ok;
  logic tx_pop_ok, tx_done_ok, rx_wr_ok, rx_end_ok;
  logic rd_last, pkt_short, sie_holds_cur;

  assign port_rdy      = alive_q & cpu_holds(cfg_tx, loaned_q[cur_q]);
  assign sie_ok        = alive_q & ~cpu_holds(cfg_tx, loaned_q[sp_q]);
  assign sie_holds_cur = ~cpu_holds(cfg_tx, loaned_q[cur_q]);

  assign cpu_wr_ok  = port_rdy & cfg_tx & cpu_wr & ~cmd_clr & ~cmd_bval
                    & (cnt_q[cur_q] < CNT_FULL);
  assign cpu_rd_ok  = port_rdy & ~cfg_tx & cpu_rd & ~cmd_clr
                    & (rptr_q < cnt_q[cur_q]);
  assign clr_ok     = cmd_clr & (port_rdy | (cfg_ctrl & alive_q));
  assign bval_ok    = cmd_bval & port_rdy & cfg_tx;
  assign tx_pop_ok  = sie_ok & cfg_tx & sie_tx_pop & (sptr_q < cnt_q[sp_q]);
  assign tx_done_ok = sie_ok & cfg_tx & sie_tx_done;
  assign rx_wr_ok   = sie_ok & ~cfg_tx & sie_rx_wr & (cnt_q[sp_q] < CNT_FULL);
  assign rx_end_ok  = sie_ok & ~cfg_tx & sie_rx_end;

  assign rd_last    = (rptr_q + CNT_ONE) == cnt_q[cur_q];
  assign pkt_short  = cnt_q[cur_q] != CNT_FULL;

  // Next-state logic: SIE events first, CPU commands after (clear wins)
  always_comb begin
    alive_n  = 1'b1;
    loaned_n = loaned_q;
    cnt_n    = cnt_q;
    cur_n    = cur_q;
    sp_n     = sp_q;
    rptr_n   = rptr_q;
    sptr_n   = sptr_q;

    if (tx_pop_ok) begin
      sptr_n = sptr_q + CNT_ONE;
    end
    if (tx_done_ok) begin
      loaned_n[sp_q] = 1'b0;
      cnt_n[sp_q]    = '0;
      sptr_n         = '0;
      if (dual_eff) sp_n = ~sp_q;
    end
    if (rx_wr_ok) begin
      cnt_n[sp_q] = cnt_q[sp_q] + CNT_ONE;
    end
    if (rx_end_ok) begin
      loaned_n[sp_q] = 1'b1;
      if (dual_eff) sp_n = ~sp_q;
    end

    if (cpu_wr_ok) begin
      cnt_n[cur_q] = cnt_q[cur_q] + CNT_ONE;
    end
    if (cpu_rd_ok) begin
      rptr_n = rptr_q + CNT_ONE;
      if (rd_last && !(cfg_bfree && pkt_short)) begin
        loaned_n[cur_q] = 1'b0;
        cnt_n[cur_q]    = '0;
        rptr_n          = '0;
        if (dual_eff) cur_n = ~cur_q;
      end
    end
    if (clr_ok) begin
      cnt_n[cur_q] = '0;
      if (cfg_tx) begin
        if (sie_holds_cur) begin
          loaned_n[cur_q] = 1'b0;
          sptr_n          = '0;
        end
      end else begin
        loaned_n[cur_q] = 1'b0;
        rptr_n          = '0;
        if (dual_eff && port_rdy) cur_n = ~cur_q;
      end
    end
    if (bval_ok) begin
      loaned_n[cur_q] = 1'b1;
      if (dual_eff) cur_n = ~cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q  <= 1'b0;
      loaned_q <= '0;
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
      cur_q    <= 1'b0;
      sp_q     <= 1'b0;
      rptr_q   <= '0;
      sptr_q   <= '0;
    end else begin
      alive_q  <= alive_n;
      loaned_q <= loaned_n;
      cnt_q[0] <= cnt_n[0];
      cnt_q[1] <= cnt_n[1];
      cur_q    <= cur_n;
      sp_q     <= sp_n;
      rptr_q   <= rptr_n;
      sptr_q   <= sptr_n;
    end
  end

  assign cpu_plane   = cur_q;
  assign sie_plane   = sp_q;
  assign cpu_cnt_raw = cnt_q[cur_q];
  assign sie_cnt_raw = cnt_q[sp_q];
  assign rptr        = rptr_q;
  assign sptr        = sptr_q;
  assign wr_en       = cpu_wr_ok | rx_wr_ok;

  // R2: a plane count never passes the plane size
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] <= CNT_FULL) && (cnt_q[1] <= CNT_FULL));

  // R4: single plane handed to the SIE drops the ready flag
  a_r4_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bval_ok && !dual_eff) |=> !port_rdy);

  // R6: clear together with buffer-valid queues an empty packet
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (bval_ok && clr_ok) |=> (cnt_q[$past(cur_q)] == '0) && loaned_q[$past(cur_q)]);

  // R9: one clear frees only one of two received planes
  a_r9_one_plane: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !cfg_tx && dual_eff && port_rdy && loaned_q[~cur_q]) |=> port_rdy);

  // R11: short packet drained under buffer-free hold keeps the flag
  a_r11_bfree_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_ok && rd_last && cfg_bfree && pkt_short) |=> port_rdy);

  // R12: a write without the ready flag leaves the count alone
  a_r12_ignore_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !port_rdy && cfg_tx && !sie_tx_done && !cmd_clr)
      |=> cnt_q[cur_q] == $past(cnt_q[cur_q]));

endmodule

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo
  import ep_fifo_pkg::*;
#(
  parameter int PLANE_BYTES = 64,
  parameter int DATA_W      = 8,
  localparam int CNT_W      = $clog2(PLANE_BYTES + 1),
  localparam int AW         = $clog2(PLANE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx,
  input  logic              cfg_dual,
  input  logic              cfg_ctrl,
  input  logic              cfg_bfree,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cmd_clr,
  input  logic              cmd_bval,
  output logic              port_rdy,
  output logic [CNT_W-1:0]  cpu_cnt,
  output logic              sie_tx_req,
  output logic [CNT_W-1:0]  sie_tx_len,
  input  logic              sie_tx_pop,
  output logic [DATA_W-1:0] sie_tx_data,
  input  logic              sie_tx_done,
  output logic              sie_rx_ready,
  input  logic              sie_rx_wr,
  input  logic [DATA_W-1:0] sie_rx_wdata,
  input  logic              sie_rx_end
);

  logic             dual_eff, sie_ok, wr_en;
  plane_t           cpu_plane, sie_plane;
  logic [CNT_W-1:0] cpu_cnt_raw, sie_cnt_raw, rptr, sptr;
  logic [DATA_W-1:0] mem_rdata;

  // The control pipe always runs on a single plane
  assign dual_eff = cfg_dual & ~cfg_ctrl;

  ep_own_ctrl #(.PLANE_BYTES(PLANE_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tx      (cfg_tx),
    .dual_eff    (dual_eff),
    .cfg_ctrl    (cfg_ctrl),
    .cfg_bfree   (cfg_bfree),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cmd_clr     (cmd_clr),
    .cmd_bval    (cmd_bval),
    .sie_tx_pop  (sie_tx_pop),
    .sie_tx_done (sie_tx_done),
    .sie_rx_wr   (sie_rx_wr),
    .sie_rx_end  (sie_rx_end),
    .port_rdy    (port_rdy),
    .sie_ok      (sie_ok),
    .cpu_plane   (cpu_plane),
    .sie_plane   (sie_plane),
    .cpu_cnt_raw (cpu_cnt_raw),
    .sie_cnt_raw (sie_cnt_raw),
    .rptr        (rptr),
    .sptr        (sptr),
    .wr_en       (wr_en)
  );

  // Writer is the CPU on transmit, the SIE on receive; the reader is the other
  ep_plane_mem #(.PLANE_BYTES(PLANE_BYTES), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .we     (wr_en),
    .wplane (cfg_tx ? cpu_plane : sie_plane),
    .widx   (cfg_tx ? cpu_cnt_raw[AW-1:0] : sie_cnt_raw[AW-1:0]),
    .wdata  (cfg_tx ? cpu_wdata : sie_rx_wdata),
    .rplane (cfg_tx ? sie_plane : cpu_plane),
    .ridx   (cfg_tx ? sptr[AW-1:0] : rptr[AW-1:0]),
    .rdata  (mem_rdata)
  );

  assign cpu_cnt      = port_rdy ? cpu_cnt_raw : '0;
  assign cpu_rdata    = (!cfg_tx && port_rdy && (rptr < cpu_cnt_raw)) ? mem_rdata : '0;
  assign sie_tx_req   = cfg_tx & sie_ok;
  assign sie_tx_len   = sie_tx_req ? sie_cnt_raw : '0;
  assign sie_tx_data  = (sie_tx_req && (sptr < sie_cnt_raw)) ? mem_rdata : '0;
  assign sie_rx_ready = ~cfg_tx & sie_ok;

endmodule

// File: tb/ep_pkt_fifo_tb.sv
module ep_pkt_fifo_tb;

  localparam int CLK_P = 10;
  localparam int PB    = 8;
  localparam int CW    = $clog2(PB + 1);

  logic clk, rst_n;
  logic cfg_tx, cfg_dual, cfg_ctrl, cfg_bfree;
  logic cpu_wr, cpu_rd, cmd_clr, cmd_bval;
  logic [7:0] cpu_wdata, cpu_rdata, sie_tx_data, sie_rx_wdata;
  logic port_rdy, sie_tx_req, sie_rx_ready;
  logic [CW-1:0] cpu_cnt, sie_tx_len;
  logic sie_tx_pop, sie_tx_done, sie_rx_wr, sie_rx_end;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_flag = 0;

  ep_pkt_fifo #(.PLANE_BYTES(PB), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_dual(cfg_dual),
    .cfg_ctrl(cfg_ctrl), .cfg_bfree(cfg_bfree), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .cmd_clr(cmd_clr), .cmd_bval(cmd_bval), .port_rdy(port_rdy),
    .cpu_cnt(cpu_cnt), .sie_tx_req(sie_tx_req), .sie_tx_len(sie_tx_len),
    .sie_tx_pop(sie_tx_pop), .sie_tx_data(sie_tx_data),
    .sie_tx_done(sie_tx_done), .sie_rx_ready(sie_rx_ready),
    .sie_rx_wr(sie_rx_wr), .sie_rx_wdata(sie_rx_wdata), .sie_rx_end(sie_rx_end)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int md [2][PB];
  int mn [2];
  int sieq [$];   // transmit planes queued for the SIE, oldest first
  int cpuq [$];   // receive planes waiting for the CPU, oldest first
  int mcur, mrx, mrp, mps;
  bit malive;

  function automatic bit inq(ref int q[$], input int v);
    foreach (q[i]) if (q[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_rdy();
    if (!malive) return 1'b0;
    if (cfg_tx) return !inq(sieq, mcur);
    return cpuq.size() > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      malive = 0; mcur = 0; mrx = 0; mrp = 0; mps = 0;
      mn[0] = 0; mn[1] = 0; sieq.delete(); cpuq.delete();
    end else begin
      bit rdy, dl, clr_ok, c_ok;
      int f, c;
      rdy = m_rdy();
      dl  = cfg_dual && !cfg_ctrl;
      clr_ok = cmd_clr && (rdy || (cfg_ctrl && malive));
      if (!malive) begin
        malive = 1;
      end else if (cfg_tx) begin
        bit wr_ok, bv_ok, pop_ok, dn_ok;
        wr_ok = rdy && cpu_wr && !cmd_clr && !cmd_bval && mn[mcur] < PB;
        bv_ok = rdy && cmd_bval;
        pop_ok = 0; dn_ok = 0; f = 0;
        if (sieq.size() > 0) begin
          f = sieq[0];
          pop_ok = sie_tx_pop && mps < mn[f];
          dn_ok  = sie_tx_done;
        end
        if (pop_ok) mps++;
        if (dn_ok) begin mn[f] = 0; mps = 0; void'(sieq.pop_front()); end
        if (wr_ok) begin md[mcur][mn[mcur]] = int'(cpu_wdata); mn[mcur]++; end
        if (clr_ok) begin
          mn[mcur] = 0;
          if (inq(sieq, mcur)) begin sieq.delete(); mps = 0; end
        end
        if (bv_ok) begin sieq.push_back(mcur); if (dl) mcur ^= 1; end
      end else begin
        bit rd_ok, w_ok, e_ok;
        c = rdy ? cpuq[0] : 0;
        c_ok  = !inq(cpuq, mrx);
        rd_ok = rdy && cpu_rd && !cmd_clr && mrp < mn[c];
        w_ok  = c_ok && sie_rx_wr && mn[mrx] < PB;
        e_ok  = c_ok && sie_rx_end;
        if (w_ok) begin md[mrx][mn[mrx]] = int'(sie_rx_wdata); mn[mrx]++; end
        if (e_ok) begin cpuq.push_back(mrx); if (dl) mrx ^= 1; end
        if (rd_ok) begin
          mrp++;
          if (mrp == mn[c] && !(cfg_bfree && mn[c] < PB)) begin
            mn[c] = 0; mrp = 0; void'(cpuq.pop_front());
          end
        end
        if (clr_ok) begin
          if (rdy) begin mn[c] = 0; mrp = 0; void'(cpuq.pop_front()); end
          else begin mn[mrx] = 0; cpuq.delete(); mrp = 0; end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      if (!rst_n) begin
        chk("R1 port_rdy in reset", int'(port_rdy), 0);
        chk("R1 tx_req in reset", int'(sie_tx_req), 0);
        chk("R1 rx_ready in reset", int'(sie_rx_ready), 0);
      end else begin
        bit r;
        int e_cnt, e_rd, e_req, e_len, e_txd, e_rxr;
        r = m_rdy();
        e_cnt = 0; e_rd = 0; e_req = 0; e_len = 0; e_txd = 0; e_rxr = 0;
        if (cfg_tx) begin
          if (r) e_cnt = mn[mcur];
          if (malive && sieq.size() > 0) begin
            e_req = 1; e_len = mn[sieq[0]];
            if (mps < mn[sieq[0]]) e_txd = md[sieq[0]][mps];
          end
        end else begin
          if (r) begin
            e_cnt = mn[cpuq[0]];
            if (mrp < mn[cpuq[0]]) e_rd = md[cpuq[0]][mrp];
          end
          e_rxr = malive && !inq(cpuq, mrx);
        end
        chk("R4 port_rdy", int'(port_rdy), int'(r));
        chk("R2 cpu_cnt", int'(cpu_cnt), e_cnt);
        chk("R8 cpu_rdata", int'(cpu_rdata), e_rd);
        chk("R3 sie_tx_req", int'(sie_tx_req), e_req);
        chk("R3 sie_tx_len", int'(sie_tx_len), e_len);
        chk("R3 sie_tx_data", int'(sie_tx_data), e_txd);
        chk("R8 sie_rx_ready", int'(sie_rx_ready), e_rxr);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr_in();
    cpu_wr = 0; cpu_rd = 0; cmd_clr = 0; cmd_bval = 0; cpu_wdata = 0;
    sie_tx_pop = 0; sie_tx_done = 0; sie_rx_wr = 0; sie_rx_end = 0; sie_rx_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; clr_in();
  endtask

  task automatic cw(input int d);  cpu_wr = 1; cpu_wdata = 8'(d); step(); endtask
  task automatic cr();             cpu_rd = 1; step(); endtask
  task automatic cc();             cmd_clr = 1; step(); endtask
  task automatic cb();             cmd_bval = 1; step(); endtask
  task automatic czl();            cmd_clr = 1; cmd_bval = 1; step(); endtask
  task automatic sp();             sie_tx_pop = 1; step(); endtask
  task automatic sd();             sie_tx_done = 1; step(); endtask
  task automatic sw(input int d);  sie_rx_wr = 1; sie_rx_wdata = 8'(d); step(); endtask
  task automatic se();             sie_rx_end = 1; step(); endtask

  task automatic do_reset(input bit tx, input bit du, input bit ct, input bit bf);
    @(posedge clk); #1;
    rst_n = 0; clr_in();
    cfg_tx = tx; cfg_dual = du; cfg_ctrl = ct; cfg_bfree = bf;
    step(); step();
    rst_n = 1;
    chk("R1 port_rdy first cycle", int'(port_rdy), 0);
    chk("R1 cpu_cnt first cycle", int'(cpu_cnt), 0);
    step();
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 0; cfg_tx = 1; cfg_dual = 0; cfg_ctrl = 0; cfg_bfree = 0;
    clr_in();

    // Transmit, one plane
    do_reset(1, 0, 0, 0);
    chk("R1 tx ready after start", int'(port_rdy), 1);
    cw(8'hA1); cw(8'hA2); cw(8'hA3);
    chk("R2 three bytes counted", int'(cpu_cnt), 3);
    cb();
    chk("R4 single plane busy", int'(port_rdy), 0);
    chk("R3 length handed", int'(sie_tx_len), 3);
    cw(8'h55);
    chk("R12 ignored write keeps length", int'(sie_tx_len), 3);
    cc();
    chk("R5 clear without ready ignored", int'(sie_tx_len), 3);
    chk("R3 first byte", int'(sie_tx_data), 8'hA1);
    sp(); sp();
    chk("R3 third byte", int'(sie_tx_data), 8'hA3);
    sp(); sd();
    chk("R3 plane returned", int'(port_rdy), 1);
    chk("R3 returned empty", int'(cpu_cnt), 0);
    for (int i = 0; i < 10; i++) cw(i + 16);
    chk("R2 overflow dropped", int'(cpu_cnt), PB);
    cc();
    chk("R5 clear empties", int'(cpu_cnt), 0);
    cw(8'h11); cw(8'h12); czl();
    chk("R6 zero-length request", int'(sie_tx_req), 1);
    chk("R6 zero length", int'(sie_tx_len), 0);
    sd();

    // Transmit, two planes
    do_reset(1, 1, 0, 0);
    cw(1); cw(2); cb();
    chk("R3 other plane free", int'(port_rdy), 1);
    cw(3); cw(4); cw(5);
    chk("R2 second plane count", int'(cpu_cnt), 3);
    cc();
    chk("R5 queued plane kept", int'(sie_tx_len), 2);
    cw(6); cw(7); cw(8); cb();
    chk("R4 both planes queued", int'(port_rdy), 0);
    sd();
    chk("R3 order kept", int'(sie_tx_len), 3);
    chk("R3 second packet data", int'(sie_tx_data), 6);
    sd();

    // Transmit control pipe
    do_reset(1, 1, 1, 0);
    cw(9); cw(10); cb();
    chk("R7 forced single plane", int'(port_rdy), 0);
    cc();
    chk("R7 clear takes SIE plane", int'(sie_tx_req), 0);
    chk("R7 plane back to CPU", int'(port_rdy), 1);

    // Receive, one plane
    do_reset(0, 0, 0, 0);
    chk("R8 sie may receive", int'(sie_rx_ready), 1);
    cr();
    chk("R12 read without ready", int'(cpu_rdata), 0);
    sw(8'hC1); sw(8'hC2); sw(8'hC3); se();
    chk("R8 packet to CPU", int'(port_rdy), 1);
    chk("R8 packet length", int'(cpu_cnt), 3);
    chk("R8 first byte", int'(cpu_rdata), 8'hC1);
    cr(); cr();
    chk("R8 third byte", int'(cpu_rdata), 8'hC3);
    cr();
    chk("R8 released after drain", int'(sie_rx_ready), 1);
    se();
    chk("R10 zero-length ready", int'(port_rdy), 1);
    chk("R10 zero-length count", int'(cpu_cnt), 0);
    cr();
    chk("R10 read does not release", int'(port_rdy), 1);
    cc();
    chk("R10 clear releases", int'(port_rdy), 0);

    // Receive, two planes
    do_reset(0, 1, 0, 0);
    sw(1); sw(2); se(); sw(3); se();
    chk("R9 both held", int'(sie_rx_ready), 0);
    cc();
    chk("R9 still ready", int'(port_rdy), 1);
    chk("R9 other packet shown", int'(cpu_cnt), 1);
    chk("R9 other data", int'(cpu_rdata), 3);
    cc();

    // Receive with buffer-free hold
    do_reset(0, 0, 0, 1);
    sw(7); sw(8); se(); cr(); cr();
    chk("R11 short held", int'(port_rdy), 1);
    chk("R11 nothing to read", int'(cpu_rdata), 0);
    cc();
    for (int i = 0; i < PB; i++) sw(i + 32);
    se();
    for (int i = 0; i < PB; i++) cr();
    chk("R11 full packet released", int'(port_rdy), 0);

    // Receive control pipe
    do_reset(0, 1, 1, 0);
    sw(5); sw(6); cc(); se();
    chk("R7 partial receive discarded", int'(cpu_cnt), 0);
    chk("R7 packet ended", int'(port_rdy), 1);
    step(); step();

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule